// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous link: a serial data input, a serial data output and a shift clock. The shift clock is either generated here (master) or taken from the far end (slave). A 4-bit processor reaches the block through a small register window. Software writes the byte as two nibbles, picks the clock source, the sampling edge and the bit order, then writes a start bit. The same data register shifts the outgoing bits out and collects the incoming bits in their place. At the end of a transfer the received byte can be read back as two nibbles.

In master mode the clock comes from the system clock, from the system clock halved, or from every second pulse of an external timer-underflow strobe. Each tick of the chosen source is one half period of the shift clock. In slave mode the external clock passes through a two-flop synchronizer and an edge detector. A ready output goes low while the slave is willing to shift. A transfer starts only after the data register has been accessed since the previous transfer. Completion raises a sticky flag, and this flag drives an interrupt request through a mask.

The control is a four-state machine:
- IDLE: not armed.
- ARMED: the data register has been read or written since the last transfer.
- HIGH: running, shift clock high, waiting for a falling event.
- LOW: running, shift clock low, waiting for a rising event.

The transitions are:
- IDLE→ARMED on a data access.
- ARMED→HIGH on a start request while enabled.
- HIGH→LOW on a falling event. The next bit is driven here, and a sample is taken if the phase bit is 1.
- LOW→HIGH on a rising event. A sample is taken if the phase bit is 0, and the bit count advances.
- LOW→IDLE on the rising event of the eighth bit. The completion flag is set here.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, every register read returns 0, `srdy` is 1, `sclk_oe` is 0 and `irq` is 0. The register addresses are:
  - 0, control: bit0 enable, bit1 start (write) or busy (read).
  - 1, mode: bits1:0 clock select, bit2 phase, bit3 order.
  - 2, data bits 3:0.
  - 3, data bits 7:4.
  - 4, bit0 interrupt mask.
  - 5, bit0 completion flag.
- R2: A start request takes effect only when enable is already 1 and the machine is ARMED, that is, address 2 or 3 was read or written since the last transfer. Otherwise busy stays 0.
- R3: Busy reads 1 from the cycle after a valid start until the eighth rising event. A start written while busy has no effect on the transfer.
- R4: The clock select codes set the half-period tick:
  - 11: every system cycle, so a master transfer keeps `sclk_oe` high for 16 cycles.
  - 10: every second cycle, so `sclk_oe` stays high for 32 cycles.
  - 01: every second timer pulse.
  - 00: external clock (slave).
- R5: In master mode `sclk_out` idles high. It is driven (`sclk_oe`=1) only while busy and gives exactly eight low pulses per transfer.
- R6: `sout` changes only when `sclk_out` falls. Bit k of the transfer is data[k] when order=0 and data[7-k] when order=1.
- R7: With phase=0 `sin` is sampled at the rising event. With phase=1 it is sampled at the falling event.
- R8: The k-th sampled bit is written to data[k] when order=0 and to data[7-k] when order=1. It is readable at addresses 2 and 3 after completion.
- R9: Completion sets the flag even when masked. Writing 1 to bit0 of address 5 clears it. `irq` equals flag AND mask.
- R10: In slave mode `sclk_in` passes through two synchronizer flops, and edges arriving before a valid start are ignored. `srdy` is 0 only while a slave transfer is busy, and it is 1 in master mode.
- R11: Writes to the data register while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms on data reads) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble |
| tmr_uflow | input | 1 | Single-cycle timer underflow pulse |
| sclk_in | input | 1 | Shift clock from pad (slave) |
| sclk_out | output | 1 | Shift clock to pad (master) |
| sclk_oe | output | 1 | Shift clock output enable |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| srdy | output | 1 | Slave ready, active low |
| irq | output | 1 | Interrupt request |

## Verification
The bench tries master transfers with `sout` looped back to `sin` under both phases. With phase 0 the byte comes back unchanged. With phase 1 it comes back displaced by one bit, because the sample lands on the same edge that drives the next bit, and this separates the two sampling edges. A pseudo-random `sin` in every clock mode and both bit orders is compared cycle by cycle with a behavioural model. The model separates the tick rates and the order mapping. Slave transfers driven with a known bit sequence, with clock toggles before the start, separate the synchronizer latency and the ignoring of early edges.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } sio_state_e;

    typedef enum logic [1:0] {
        CK_EXT  = 2'b00,
        CK_TMR  = 2'b01,
        CK_DIV2 = 2'b10,
        CK_FAST = 2'b11
    } sio_clk_e;

    localparam logic [2:0] A_CTL  = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_DLO  = 3'd2;
    localparam logic [2:0] A_DHI  = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;
    localparam logic [2:0] A_FLAG = 3'd5;
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
    import sio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  sio_clk_e mode,
    input  logic     tmr_pulse,
    output logic     tick
);
    logic div_q;

    // Divide-by-two phase, held at zero between transfers so timing is fixed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= 1'b0;
        else if (!run)
            div_q <= 1'b0;
        else if (mode == CK_DIV2 || (mode == CK_TMR && tmr_pulse))
            div_q <= ~div_q;
    end

    always_comb begin
        unique case (mode)
            CK_FAST: tick = run;
            CK_DIV2: tick = run & div_q;
            CK_TMR:  tick = run & tmr_pulse & div_q;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic rise
);
    logic [STAGES:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '1;
        else
            q <= {q[STAGES-1:0], pin};
    end

    assign fall = q[STAGES] & ~q[STAGES-1];
    assign rise = ~q[STAGES] & q[STAGES-1];
endmodule

// File: rtl/sio_shift_fsm.sv
module sio_shift_fsm
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NIB_W = DATA_W / 2,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              phase,
    input  logic              order,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              data_acc,
    input  logic              trig,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [NIB_W-1:0]  wdata,
    input  logic              sin,
    output sio_state_e        state,
    output logic [DATA_W-1:0] data,
    output logic              sout,
    output logic              done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    sio_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              sout_q;
    logic              shift_out, sample, running;
    logic [CNT_W-1:0]  pos;

    assign running = (state_q == ST_HIGH) || (state_q == ST_LOW);
    assign pos     = order ? (LAST - cnt_q) : cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and per-cycle actions
    always_comb begin
        state_d   = state_q;
        shift_out = 1'b0;
        sample    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (data_acc) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (trig && en) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (fall_ev) begin
                    state_d   = ST_LOW;
                    shift_out = 1'b1;
                    sample    = phase;
                end
            end
            ST_LOW: begin
                if (rise_ev) begin
                    sample = ~phase;
                    if (cnt_q == LAST) begin
                        state_d = ST_IDLE;
                        done    = 1'b1;
                    end else begin
                        state_d = ST_HIGH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            data_q <= '0;
            sout_q <= 1'b1;
        end else begin
            if (!running)
                cnt_q <= '0;
            else if (state_q == ST_LOW && rise_ev)
                cnt_q <= cnt_q + 1'b1;

            if (shift_out)
                sout_q <= data_q[pos];

            if (sample)
                data_q[pos] <= sin;
            else if (!running) begin
                if (wr_lo) data_q[NIB_W-1:0]      <= wdata;
                if (wr_hi) data_q[DATA_W-1:NIB_W] <= wdata;
            end
        end
    end

    assign state = state_q;
    assign data  = data_q;
    assign sout  = sout_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NIB_W      = DATA_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [NIB_W-1:0] bus_wdata,
    output logic [NIB_W-1:0] bus_rdata,
    input  logic             tmr_uflow,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    input  logic             sin,
    output logic             sout,
    output logic             srdy,
    output logic             irq
);
    logic              en_q, phase_q, order_q, mask_q, flag_q;
    sio_clk_e          mode_q;
    sio_state_e        state;
    logic [DATA_W-1:0] data;
    logic              run, master, tick, ext_fall, ext_rise, done;
    logic              fall_ev, rise_ev, data_acc, trig, wr_lo, wr_hi;

    assign run      = (state == ST_HIGH) || (state == ST_LOW);
    assign master   = (mode_q != CK_EXT);
    assign data_acc = (bus_wr || bus_rd) && (bus_addr == A_DLO || bus_addr == A_DHI);
    assign wr_lo    = bus_wr && bus_addr == A_DLO;
    assign wr_hi    = bus_wr && bus_addr == A_DHI;
    assign trig     = bus_wr && bus_addr == A_CTL && bus_wdata[1];
    assign fall_ev  = master ? tick : ext_fall;
    assign rise_ev  = master ? tick : ext_rise;

    sio_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode_q),
        .tmr_pulse(tmr_uflow), .tick(tick)
    );

    sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk_in),
        .fall(ext_fall), .rise(ext_rise)
    );

    sio_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .phase(phase_q), .order(order_q),
        .fall_ev(fall_ev), .rise_ev(rise_ev), .data_acc(data_acc), .trig(trig),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata), .sin(sin),
        .state(state), .data(data), .sout(sout), .done(done)
    );

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= CK_EXT;
            phase_q <= 1'b0;
            order_q <= 1'b0;
            mask_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTL)  en_q <= bus_wdata[0];
            if (bus_wr && bus_addr == A_MODE) begin
                mode_q  <= sio_clk_e'(bus_wdata[1:0]);
                phase_q <= bus_wdata[2];
                order_q <= bus_wdata[3];
            end
            if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[0];
            if (done)
                flag_q <= 1'b1;
            else if (bus_wr && bus_addr == A_FLAG && bus_wdata[0])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTL:   bus_rdata = {{(NIB_W-2){1'b0}}, run, en_q};
            A_MODE:  bus_rdata = NIB_W'({order_q, phase_q, mode_q});
            A_DLO:   bus_rdata = data[NIB_W-1:0];
            A_DHI:   bus_rdata = data[DATA_W-1:NIB_W];
            A_MASK:  bus_rdata = {{(NIB_W-1){1'b0}}, mask_q};
            A_FLAG:  bus_rdata = {{(NIB_W-1){1'b0}}, flag_q};
            default: bus_rdata = '0;
        endcase
    end

    assign sclk_out = (state != ST_LOW);
    assign sclk_oe  = master & run;
    assign srdy     = ~(~master & run);
    assign irq      = flag_q & mask_q;
endmodule

// File: rtl/sync_serial_xcvr_chk.sv
module sync_serial_xcvr_chk
    import sio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [3:0] bus_wdata,
    input logic       sout,
    input logic       sclk_out,
    input logic       sclk_oe,
    input logic       srdy,
    input logic       run,
    input logic       flag_q,
    input sio_clk_e   mode_q,
    input sio_state_e state
);
    a_r6_sout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sout) |-> $fell(sclk_out));

    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> sclk_out);

    a_r5_oe_master: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe |-> (mode_q != CK_EXT) && run);

    a_r10_srdy_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !srdy |-> (mode_q == CK_EXT) && run);

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(bus_wr && bus_addr == A_FLAG && bus_wdata[0]) |=> flag_q);

    a_r2_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(state) == ST_ARMED);
endmodule

bind sync_serial_xcvr sync_serial_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sout(sout), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .srdy(srdy), .run(run), .flag_q(flag_q), .mode_q(mode_q), .state(state)
);

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [3:0] bus_wdata = 0;
    logic [3:0] bus_rdata;
    logic       tmr_uflow = 0, sclk_in = 1, sin_drv = 0, loop = 0;
    logic       sclk_out, sclk_oe, sout, srdy, irq;
    wire        sin = loop ? sout : sin_drv;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sync_serial_xcvr uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_uflow(tmr_uflow), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sin(sin), .sout(sout), .srdy(srdy), .irq(irq)
    );

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_st = 0, m_cnt = 0, m_mode = 0;
    bit   m_en = 0, m_phase = 0, m_order = 0, m_mask = 0, m_flag = 0, m_sout = 1, m_div = 0;
    bit [7:0] m_data = 0;
    bit   hist[$] = '{1, 1, 1};
    // input snapshots taken away from the active edge
    bit   s_rst = 0, s_wr = 0, s_rd = 0, s_tmr = 0, s_sclk = 1, s_sin = 0;
    int   s_addr = 0;
    bit [3:0] s_wd = 0;

    function automatic int bitpos(int k);
        return m_order ? 7 - k : k;
    endfunction

    always @(posedge clk) begin
        if (!s_rst) begin
            m_st = 0; m_cnt = 0; m_mode = 0; m_en = 0; m_phase = 0; m_order = 0;
            m_mask = 0; m_flag = 0; m_sout = 1; m_div = 0; m_data = 0;
            hist = '{1, 1, 1};
        end else begin
            bit run, master, tick, fe, re, done, acc;
            run = (m_st >= 2);
            master = (m_mode != 0);
            case (m_mode)
                3: tick = run;
                2: tick = run && m_div;
                1: tick = run && s_tmr && m_div;
                default: tick = 0;
            endcase
            fe = master ? tick : (hist[$-2] && !hist[$-1]);
            re = master ? tick : (!hist[$-2] && hist[$-1]);
            hist.push_back(s_sclk);
            if (hist.size() > 4) void'(hist.pop_front());
            acc = (s_wr || s_rd) && (s_addr == 2 || s_addr == 3);
            done = 0;
            case (m_st)
                0: if (acc) m_st = 1;
                1: if (s_wr && s_addr == 0 && s_wd[1] && m_en) m_st = 2;
                2: if (fe) begin
                       m_sout = m_data[bitpos(m_cnt)];
                       if (m_phase) m_data[bitpos(m_cnt)] = s_sin;
                       m_st = 3;
                   end
                default: if (re) begin
                       if (!m_phase) m_data[bitpos(m_cnt)] = s_sin;
                       if (m_cnt == 7) begin m_st = 0; m_cnt = 0; done = 1; end
                       else begin m_cnt++; m_st = 2; end
                   end
            endcase
            if (!run && s_wr && s_addr == 2) m_data[3:0] = s_wd;
            if (!run && s_wr && s_addr == 3) m_data[7:4] = s_wd;
            if (!run) m_div = 0;
            else if (m_mode == 2 || (m_mode == 1 && s_tmr)) m_div = !m_div;
            if (s_wr && s_addr == 0) m_en = s_wd[0];
            if (s_wr && s_addr == 1) begin
                m_mode = int'(s_wd[1:0]); m_phase = s_wd[2]; m_order = s_wd[3];
            end
            if (s_wr && s_addr == 4) m_mask = s_wd[0];
            if (done) m_flag = 1;
            else if (s_wr && s_addr == 5 && s_wd[0]) m_flag = 0;
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    bit   prev_sclk = 1;
    bit   tx_log[$];
    int   oe_cnt = 0;

    always @(negedge clk) begin
        #1;
        cyc++;
        s_rst = rst_n; s_wr = bus_wr; s_rd = bus_rd; s_addr = int'(bus_addr);
        s_wd = bus_wdata; s_tmr = tmr_uflow; s_sclk = sclk_in; s_sin = sin;
        if (rst_n && !finished) begin
            bit [3:0] exp_rd;
            case (bus_addr)
                0: exp_rd = {2'b00, (m_st >= 2), m_en};
                1: exp_rd = {m_order, m_phase, 2'(m_mode)};
                2: exp_rd = m_data[3:0];
                3: exp_rd = m_data[7:4];
                4: exp_rd = {3'b0, m_mask};
                5: exp_rd = {3'b0, m_flag};
                default: exp_rd = 0;
            endcase
            chk("R5", "model sclk_out", int'(sclk_out), int'(m_st != 3));
            chk("R5", "model sclk_oe", int'(sclk_oe), int'(m_mode != 0 && m_st >= 2));
            chk("R6", "model sout", int'(sout), int'(m_sout));
            chk("R10", "model srdy", int'(srdy), int'(!(m_mode == 0 && m_st >= 2)));
            chk("R9", "model irq", int'(irq), int'(m_flag && m_mask));
            chk("R1", "model rdata", int'(bus_rdata), int'(exp_rd));
            if (prev_sclk && !sclk_out) tx_log.push_back(sout);
            prev_sclk = sclk_out;
            if (sclk_oe) oe_cnt++;
        end
    end

    // background stimulus: timer pulses and pseudo-random serial input
    initial begin
        bit [7:0] lfsr = 8'h5a;
        forever begin
            @(negedge clk);
            tmr_uflow = (cyc % 3 == 0);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            sin_drv = lfsr[0];
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input int a, input bit [3:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output bit [3:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = 3'(a);
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_idle();
        bit [3:0] v;
        for (int k = 0; k < 2000; k++) begin
            rd(0, v);
            if (!v[1]) break;
        end
    endtask

    task automatic xfer_master(int mode, bit ph, bit ord, bit [7:0] b, bit lp,
                               bit mid_wr, bit retrig);
        bit [3:0] v, lo, hi;
        bit sb;
        bit [7:0] exp;
        loop = lp;
        wr(5, 4'h1);
        wr(1, {ord, ph, 2'(mode)});
        wr(2, b[3:0]);
        wr(3, b[7:4]);
        sb = sout;
        tx_log.delete(); oe_cnt = 0;
        wr(0, 4'b0011);
        rd(0, v);
        chk("R3", "busy after start", int'(v[1]), 1);
        if (mid_wr) wr(2, ~b[3:0]);
        if (retrig) wr(0, 4'b0011);
        wait_idle();
        chk("R5", "low pulses", tx_log.size(), 8);
        for (int i = 0; i < 8 && i < tx_log.size(); i++)
            chk("R6", "sent bit", int'(tx_log[i]), int'(ord ? b[7-i] : b[i]));
        if (mode == 3) chk("R4", "oe cycles fast", oe_cnt, 16);
        if (mode == 2) chk("R4", "oe cycles div2", oe_cnt, 32);
        rd(5, v);
        chk("R9", "flag set", int'(v[0]), 1);
        if (lp) begin
            rd(2, lo); rd(3, hi);
            if (!ph) exp = b;
            else exp = ord ? {sb, b[7:1]} : {b[6:0], sb};
            chk(ph ? "R7" : "R8", "loopback byte", int'({hi, lo}), int'(exp));
            if (mid_wr) chk("R11", "write while busy ignored", int'({hi, lo}), int'(exp));
        end
        loop = 0;
    endtask

    task automatic xfer_slave(bit ph, bit ord, bit [7:0] txb, bit [7:0] seq, bit noise);
        bit [3:0] v, lo, hi;
        bit [7:0] exp;
        wr(5, 4'h1);
        wr(1, {ord, ph, 2'b00});
        wr(2, txb[3:0]);
        wr(3, txb[7:4]);
        if (noise) begin
            for (int i = 0; i < 3; i++) begin
                repeat (4) @(negedge clk); sclk_in = 0;
                repeat (4) @(negedge clk); sclk_in = 1;
            end
            repeat (6) @(negedge clk);
            rd(0, v);
            chk("R10", "early edges ignored", int'(v[1]), 0);
            rd(2, lo);
            chk("R10", "data untouched before start", int'(lo), int'(txb[3:0]));
        end
        tx_log.delete();
        wr(0, 4'b0011);
        rd(0, v);
        chk("R3", "slave busy", int'(v[1]), 1);
        chk("R10", "srdy low in slave", int'(srdy), 0);
        for (int i = 0; i < 8; i++) begin
            sin_drv_hold = 1; sin_force = seq[i];
            repeat (4) @(negedge clk); sclk_in = 0;
            repeat (4) @(negedge clk); sclk_in = 1;
            repeat (4) @(negedge clk);
        end
        sin_drv_hold = 0;
        rd(0, v);
        chk("R3", "slave done", int'(v[1]), 0);
        chk("R10", "srdy high after", int'(srdy), 1);
        chk("R5", "slave falls", tx_log.size(), 8);
        for (int i = 0; i < 8 && i < tx_log.size(); i++)
            chk("R6", "slave sent bit", int'(tx_log[i]), int'(ord ? txb[7-i] : txb[i]));
        for (int i = 0; i < 8; i++) exp[ord ? 7 - i : i] = seq[i];
        rd(2, lo); rd(3, hi);
        chk("R8", "slave received", int'({hi, lo}), int'(exp));
    endtask

    // sin override for slave transfers (keeps bit stable over both edges)
    bit sin_drv_hold = 0, sin_force = 0;
    always @(negedge clk) if (sin_drv_hold) sin_drv <= sin_force;

    // ---------------- directed sequence ----------------
    initial begin
        bit [3:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            if (a == 2 || a == 3) continue;
            rd(a, v);
            chk("R1", "reset register", int'(v), 0);
        end
        chk("R1", "reset srdy", int'(srdy), 1);
        chk("R1", "reset oe", int'(sclk_oe), 0);
        chk("R1", "reset irq", int'(irq), 0);

        wr(1, 4'b0011);
        wr(0, 4'b0001);
        wr(0, 4'b0011);
        rd(0, v);
        chk("R2", "start without arming", int'(v[1]), 0);
        wr(0, 4'b0000);
        wr(2, 4'h5);
        wr(0, 4'b0010);
        rd(0, v);
        chk("R2", "start while disabled", int'(v[1]), 0);
        wr(0, 4'b0001);

        xfer_master(3, 0, 0, 8'hA5, 1, 0, 0);
        chk("R9", "masked irq low", int'(irq), 0);
        wr(4, 4'h1);
        @(negedge clk);
        chk("R9", "unmasked irq", int'(irq), 1);
        wr(5, 4'h1);
        rd(5, v);
        chk("R9", "flag cleared", int'(v[0]), 0);
        chk("R9", "irq after clear", int'(irq), 0);

        xfer_master(3, 0, 1, 8'h3C, 1, 1, 1);
        xfer_master(2, 1, 0, 8'h96, 1, 0, 0);
        xfer_master(2, 1, 1, 8'h71, 1, 0, 0);
        xfer_master(1, 0, 1, 8'hE2, 0, 0, 0);
        xfer_master(2, 1, 0, 8'h0F, 0, 0, 0);
        xfer_master(3, 1, 1, 8'hC9, 0, 0, 0);

        xfer_slave(0, 0, 8'h5E, 8'hB4, 1);
        xfer_slave(1, 1, 8'h83, 8'h2D, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        finished = 1;
        errors++; checks++;
        $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule